// File: doc/BRIEF.md
# Error-Driven Supply Voltage Speculation Governor

This block is a per-core controller. It sets a digital supply-voltage code (1 LSB = 1 mV) from reports of correctable ECC errors. Its inputs are a single-cycle error pulse, a once-per-minute timebase tick, a context-switch pulse and a class flag that marks the core as aggressive or conservative. It also takes a programmed margin code, a safety pad, a nominal maximum code, and a minimum and a maximum error-rate threshold. The error rate is the number of error pulses counted inside one tick-to-tick window.

A core in conservative behaviour reacts to each error by raising the code by 10 mV. After each quiet minute it lowers the code by 5 mV, and it never lowers the code below its floor, which is the margin plus the pad. An arm pulse on an aggressive-class core starts speculation. During speculation the code steps down by 5 mV per window, with no floor, while the window count stays under the maximum threshold. When the count equals the maximum, the code is frozen. Speculation ends when the rate goes above the maximum, when the rate falls below the minimum, or on a context switch. The code is then lifted back to at least the floor.

Top module: `vspec_gov`

## Requirements
- R1: While reset is asserted and right after it, `vcode_o` equals `vmax_code_i`, `mode_o` is 0 (conservative) and `spec_active_o` is 0. The window counter starts at zero.
- R2: In conservative mode (`mode_o`=0), a cycle with `corr_err_i` high raises `vcode_o` by 10 on the next cycle. The result saturates at `vmax_code_i`.
- R3: In conservative mode, a tick with no error in the elapsed window and none in the tick cycle lowers the code by 5. The code is never taken below the floor: if it is within 5 of the floor it lands on the floor, and if it is already below the floor it is unchanged.
- R4: The floor is `margin_code_i + pad_code_i`, capped at `vmax_code_i`.
- R5: When an error and a tick arrive in the same cycle, the rise wins and no decrement happens. The window restarts at that tick, so the next tick with no error in between lowers the code.
- R6: An `spec_arm_i` pulse in conservative mode with `aggr_class_i` high sets `mode_o` to 1 (stepping down) on the next cycle. With `aggr_class_i` low, the pulse has no effect.
- R7: In mode 1, a tick whose window count w satisfies `err_min_i` <= w < `err_max_i` lowers the code by 5, which may take it below the margin (saturating at 0). Outside a tick, errors leave the code unchanged during speculation.
- R8: In mode 1, a tick with w equal to `err_max_i` sets `mode_o` to 2 (hold) and keeps the code. In mode 2, ticks with `err_min_i` <= w <= `err_max_i` keep both the mode and the code.
- R9: In mode 1 or 2, any of these returns the block to mode 0 on the next cycle: `ctx_switch_i`, a tick with w > `err_max_i`, or a tick with w < `err_min_i`. The code becomes max(code, floor), and `spec_active_o` is high exactly when `mode_o` is not 0.
- R10: The window count w includes an error in the tick cycle itself. It saturates at 2^CW-1 and clears at every tick.
- R11: `vcode_o` never stays above `vmax_code_i`. After the maximum is lowered, the code is clamped to it on the next cycle.
- R12: After speculation ends, the block stays in mode 0 until a new arm pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| corr_err_i | input | 1 | Correctable-error pulse, one per error |
| minute_tick_i | input | 1 | One-cycle pulse ending each rate window |
| ctx_switch_i | input | 1 | Context-switch pulse; ends speculation |
| spec_arm_i | input | 1 | Pulse that starts a speculation phase |
| aggr_class_i | input | 1 | 1 = aggressive-class core |
| margin_code_i | input | VW | Margin voltage code, mV |
| pad_code_i | input | PW | Safety pad added to the margin, mV |
| vmax_code_i | input | VW | Nominal maximum voltage code, mV |
| err_max_i | input | CW | Maximum errors per window |
| err_min_i | input | CW | Minimum errors per window |
| vcode_o | output | VW | Supply voltage code, mV |
| mode_o | output | 2 | 0 conservative, 1 stepping down, 2 hold |
| spec_active_o | output | 1 | High during speculation |

## Verification
The bench targets the following corner cases:
- **Error and tick in the same cycle.** A design that lets the decrement win would show a 5 mV drop where a 10 mV rise is due.
- **Approach to the floor.** A code within 5 of the floor must stop exactly on it, and a code already below the floor must stay put. A wrong design would either undershoot or pull the code up.
- **Window count at the threshold.** With the counter saturated and the maximum at 2^CW-1, the block must enter hold. With the maximum one lower, the block must exit. A counter that wraps would step down instead.
- **Exit lift and a lowered maximum.** A missing floor lift, or a missing clamp, leaves the code at a level that is out of bounds.

// File: rtl/vspec_pkg.sv
package vspec_pkg;
  typedef enum logic [1:0] {
    MODE_CONS = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_HOLD = 2'd2
  } mode_t;

  typedef enum logic [2:0] {
    OP_KEEP       = 3'd0,
    OP_RAISE      = 3'd1,
    OP_DROP_FLOOR = 3'd2,
    OP_DROP_FREE  = 3'd3,
    OP_LIFT       = 3'd4
  } vop_t;
endpackage

// File: rtl/vspec_errwin.sv
// Per-window error counter: saturating, cleared at each tick.
module vspec_errwin #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_i,
  input  logic          tick_i,
  output logic [CW-1:0] win_o,
  output logic          quiet_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          bump;

  assign bump = err_i && (cnt_q != CMAX);

  always_comb begin
    cnt_en = tick_i || bump;
    cnt_d  = tick_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Count of the window that closes in this cycle, tick-cycle error included
  assign win_o   = bump ? cnt_q + 1'b1 : cnt_q;
  assign quiet_o = (cnt_q == '0) && !err_i;
endmodule

// File: rtl/vspec_floor.sv
// Padded floor for conservative behaviour, capped at the nominal maximum.
module vspec_floor #(
  parameter int VW = 11,
  parameter int PW = 6
) (
  input  logic [VW-1:0] margin_i,
  input  logic [PW-1:0] pad_i,
  input  logic [VW-1:0] vmax_i,
  output logic [VW-1:0] floor_o
);
  logic [VW:0] sum_x;
  logic [VW:0] vmax_x;

  always_comb begin
    sum_x   = {1'b0, margin_i} + (VW+1)'(pad_i);
    vmax_x  = {1'b0, vmax_i};
    floor_o = (sum_x > vmax_x) ? vmax_i : sum_x[VW-1:0];
  end
endmodule

// File: rtl/vspec_vstep.sv
// Voltage-code datapath: applies one step operation and the maximum clamp.
module vspec_vstep
  import vspec_pkg::*;
#(
  parameter int VW      = 11,
  parameter int UP_STEP = 10,
  parameter int DN_STEP = 5
) (
  input  logic [VW-1:0] cur_i,
  input  logic [VW-1:0] floor_i,
  input  logic [VW-1:0] vmax_i,
  input  vop_t          op_i,
  output logic [VW-1:0] next_o
);
  localparam logic [VW:0] UP_X = (VW+1)'(UP_STEP);
  localparam logic [VW:0] DN_X = (VW+1)'(DN_STEP);

  logic [VW:0] cur_x, floor_x, vmax_x, res_x;

  always_comb begin
    cur_x   = {1'b0, cur_i};
    floor_x = {1'b0, floor_i};
    vmax_x  = {1'b0, vmax_i};
    res_x   = cur_x;
    case (op_i)
      OP_RAISE:      res_x = cur_x + UP_X;
      OP_DROP_FLOOR: begin
        if (cur_x > floor_x)
          res_x = ((cur_x - floor_x) > DN_X) ? cur_x - DN_X : floor_x;
      end
      OP_DROP_FREE:  res_x = (cur_x >= DN_X) ? cur_x - DN_X : '0;
      OP_LIFT:       begin
        if (cur_x < floor_x) res_x = floor_x;
      end
      default:       res_x = cur_x;
    endcase
    next_o = (res_x > vmax_x) ? vmax_i : res_x[VW-1:0];
  end
endmodule

// File: rtl/vspec_ctrl.sv
// Mode sequencer: picks the voltage operation and the next mode.
module vspec_ctrl
  import vspec_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_i,
  input  logic          tick_i,
  input  logic          ctx_i,
  input  logic          arm_i,
  input  logic          aggr_i,
  input  logic [CW-1:0] win_i,
  input  logic          quiet_i,
  input  logic [CW-1:0] thr_max_i,
  input  logic [CW-1:0] thr_min_i,
  output vop_t          op_o,
  output mode_t         mode_o
);
  mode_t mode_q, mode_d;
  logic  mode_en;
  logic  rate_high, rate_low, rate_at_max;

  always_comb begin
    rate_high   = win_i > thr_max_i;
    rate_low    = win_i < thr_min_i;
    rate_at_max = win_i == thr_max_i;
  end

  always_comb begin
    mode_d = mode_q;
    op_o   = OP_KEEP;
    case (mode_q)
      MODE_CONS: begin
        if (err_i)                  op_o = OP_RAISE;
        else if (tick_i && quiet_i) op_o = OP_DROP_FLOOR;
        if (arm_i && aggr_i)        mode_d = MODE_DOWN;
      end
      MODE_DOWN, MODE_HOLD: begin
        if (ctx_i || (tick_i && (rate_high || rate_low))) begin
          mode_d = MODE_CONS;
          op_o   = OP_LIFT;
        end else if (tick_i && (mode_q == MODE_DOWN)) begin
          if (rate_at_max) mode_d = MODE_HOLD;
          else             op_o   = OP_DROP_FREE;
        end
      end
      default: mode_d = MODE_CONS;
    endcase
    mode_en = (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_CONS;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/vspec_gov.sv
module vspec_gov
  import vspec_pkg::*;
#(
  parameter int VW      = 11,
  parameter int PW      = 6,
  parameter int CW      = 4,
  parameter int UP_STEP = 10,
  parameter int DN_STEP = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          corr_err_i,
  input  logic          minute_tick_i,
  input  logic          ctx_switch_i,
  input  logic          spec_arm_i,
  input  logic          aggr_class_i,
  input  logic [VW-1:0] margin_code_i,
  input  logic [PW-1:0] pad_code_i,
  input  logic [VW-1:0] vmax_code_i,
  input  logic [CW-1:0] err_max_i,
  input  logic [CW-1:0] err_min_i,
  output logic [VW-1:0] vcode_o,
  output logic [1:0]    mode_o,
  output logic          spec_active_o
);
  logic [CW-1:0] win;
  logic          quiet;
  logic [VW-1:0] floor_code;
  logic [VW-1:0] cur_code, next_code;
  logic [VW-1:0] v_q;
  logic          loaded_q;
  logic          v_en;
  vop_t          op;
  mode_t         mode;

  vspec_errwin #(.CW(CW)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_i   (corr_err_i),
    .tick_i  (minute_tick_i),
    .win_o   (win),
    .quiet_o (quiet)
  );

  vspec_floor #(.VW(VW), .PW(PW)) u_floor (
    .margin_i (margin_code_i),
    .pad_i    (pad_code_i),
    .vmax_i   (vmax_code_i),
    .floor_o  (floor_code)
  );

  vspec_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_i     (corr_err_i),
    .tick_i    (minute_tick_i),
    .ctx_i     (ctx_switch_i),
    .arm_i     (spec_arm_i),
    .aggr_i    (aggr_class_i),
    .win_i     (win),
    .quiet_i   (quiet),
    .thr_max_i (err_max_i),
    .thr_min_i (err_min_i),
    .op_o      (op),
    .mode_o    (mode)
  );

  vspec_vstep #(.VW(VW), .UP_STEP(UP_STEP), .DN_STEP(DN_STEP)) u_step (
    .cur_i   (cur_code),
    .floor_i (floor_code),
    .vmax_i  (vmax_code_i),
    .op_i    (op),
    .next_o  (next_code)
  );

  // Until the first edge after reset the code tracks the nominal maximum.
  assign cur_code = loaded_q ? v_q : vmax_code_i;
  assign v_en     = !loaded_q || (next_code != v_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q      <= '0;
      loaded_q <= 1'b0;
    end else begin
      loaded_q <= 1'b1;
      if (v_en) v_q <= next_code;
    end
  end

  assign vcode_o       = cur_code;
  assign mode_o        = mode;
  assign spec_active_o = (mode != MODE_CONS);
endmodule

// File: rtl/vspec_gov_chk.sv
module vspec_gov_chk #(
  parameter int VW      = 11,
  parameter int PW      = 6,
  parameter int CW      = 4,
  parameter int UP_STEP = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          corr_err_i,
  input logic          minute_tick_i,
  input logic          ctx_switch_i,
  input logic          aggr_class_i,
  input logic [VW-1:0] margin_code_i,
  input logic [PW-1:0] pad_code_i,
  input logic [VW-1:0] vmax_code_i,
  input logic [VW-1:0] vcode_o,
  input logic [1:0]    mode_o,
  input logic          spec_active_o
);
  logic [VW:0] pad_sum;
  logic [VW:0] flr;
  logic [VW:0] up_exp;

  always_comb begin
    pad_sum = {1'b0, margin_code_i} + (VW+1)'(pad_code_i);
    flr     = (pad_sum > {1'b0, vmax_code_i}) ? {1'b0, vmax_code_i} : pad_sum;
    up_exp  = {1'b0, vcode_o} + (VW+1)'(UP_STEP);
    if (up_exp > {1'b0, vmax_code_i}) up_exp = {1'b0, vmax_code_i};
  end

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd3 && (spec_active_o == (mode_o != 2'd0))); // R9
  AST_VCODE_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (vcode_o <= vmax_code_i) || (vmax_code_i != $past(vmax_code_i))); // R11
  AST_CONS_ERR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && corr_err_i) |=> ({1'b0, vcode_o} == $past(up_exp)) || (vmax_code_i != $past(vmax_code_i))); // R2
  AST_CONS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && !corr_err_i && {1'b0, vcode_o} >= flr) |=> ({1'b0, vcode_o} >= $past(flr)) || (vmax_code_i != $past(vmax_code_i))); // R3
  AST_CTX_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_active_o && ctx_switch_i) |=> !spec_active_o && (({1'b0, vcode_o} >= $past(flr)) || (vmax_code_i != $past(vmax_code_i)))); // R9
  AST_SPEC_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_active_o && !minute_tick_i && !ctx_switch_i) |=> $stable(vcode_o) || (vmax_code_i != $past(vmax_code_i))); // R7
  AST_CLASS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && !aggr_class_i) |=> mode_o == 2'd0); // R6
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |-> (mode_o == 2'd0 && !spec_active_o && vcode_o == vmax_code_i)); // R1
endmodule

bind vspec_gov vspec_gov_chk #(.VW(VW), .PW(PW), .CW(CW), .UP_STEP(UP_STEP)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .corr_err_i    (corr_err_i),
  .minute_tick_i (minute_tick_i),
  .ctx_switch_i  (ctx_switch_i),
  .aggr_class_i  (aggr_class_i),
  .margin_code_i (margin_code_i),
  .pad_code_i    (pad_code_i),
  .vmax_code_i   (vmax_code_i),
  .vcode_o       (vcode_o),
  .mode_o        (mode_o),
  .spec_active_o (spec_active_o)
);

// File: tb/tb_vspec_gov.sv
module tb_vspec_gov;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 11;
  localparam int PW = 6;
  localparam int CW = 4;
  localparam int CSAT = (1 << CW) - 1;

  logic          clk;
  logic          rst_n;
  logic          err, tick, ctx, arm, aggr;
  logic [VW-1:0] margin, vmax;
  logic [PW-1:0] pad;
  logic [CW-1:0] tmax, tmin;
  logic [VW-1:0] vcode;
  logic [1:0]    mode;
  logic          active;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // reference state
  int m_v, m_mode, m_cnt;

  vspec_gov #(.VW(VW), .PW(PW), .CW(CW)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .corr_err_i    (err),
    .minute_tick_i (tick),
    .ctx_switch_i  (ctx),
    .spec_arm_i    (arm),
    .aggr_class_i  (aggr),
    .margin_code_i (margin),
    .pad_code_i    (pad),
    .vmax_code_i   (vmax),
    .err_max_i     (tmax),
    .err_min_i     (tmin),
    .vcode_o       (vcode),
    .mode_o        (mode),
    .spec_active_o (active)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int floor_of();
    int f;
    f = int'(margin) + int'(pad);
    if (f > int'(vmax)) f = int'(vmax);
    return f;
  endfunction

  // Next reference state from the requirements
  task automatic model_step(input bit e, input bit t, input bit c, input bit s);
    int fl, w, nv, nm;
    fl = floor_of();
    w  = m_cnt + ((e && m_cnt < CSAT) ? 1 : 0);
    nv = m_v;
    nm = m_mode;
    if (m_mode == 0) begin
      if (e) nv = m_v + 10;                                   // R2
      else if (t && m_cnt == 0) begin                         // R3, R5
        if (m_v > fl) nv = (m_v - fl > 5) ? m_v - 5 : fl;
      end
      if (s && aggr) nm = 1;                                  // R6
    end else begin
      if (c || (t && (w > int'(tmax) || w < int'(tmin)))) begin   // R9
        nm = 0;
        if (nv < fl) nv = fl;
      end else if (t && m_mode == 1) begin
        if (w == int'(tmax)) nm = 2;                          // R8
        else nv = (m_v >= 5) ? m_v - 5 : 0;                   // R7
      end
    end
    if (nv > int'(vmax)) nv = int'(vmax);                     // R11
    if (t) m_cnt = 0;                                         // R10
    else if (e && m_cnt < CSAT) m_cnt = m_cnt + 1;
    m_v = nv;
    m_mode = nm;
  endtask

  task automatic check_out(input string tag);
    n_checks++;
    if (int'(vcode) != m_v || int'(mode) != m_mode || active != (m_mode != 0)) begin
      n_errors++;
      $display("FAIL %s: vcode=%0d mode=%0d active=%0d expected vcode=%0d mode=%0d active=%0d",
               tag, vcode, mode, active, m_v, m_mode, (m_mode != 0));
    end
  endtask

  task automatic expect_v(input string tag, input int exp_v, input int exp_m);
    n_checks++;
    if (int'(vcode) != exp_v || int'(mode) != exp_m) begin
      n_errors++;
      $display("FAIL %s: vcode=%0d mode=%0d expected vcode=%0d mode=%0d",
               tag, vcode, mode, exp_v, exp_m);
    end
  endtask

  // One clock: drive at the falling edge, compare at the next falling edge
  task automatic cyc(input bit e, input bit t, input bit c, input bit s, input string tag);
    err = e; tick = t; ctx = c; arm = s;
    model_step(e, t, c, s);
    @(posedge clk);
    @(negedge clk);
    err = 1'b0; tick = 1'b0; ctx = 1'b0; arm = 1'b0;
    check_out(tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240613));
    rst_n = 1'b0;
    err = 0; tick = 0; ctx = 0; arm = 0; aggr = 0;
    margin = 11'd900; pad = 6'd20; vmax = 11'd1000;
    tmax = 4'd1; tmin = 4'd0;
    m_v = 1000; m_mode = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    expect_v("R1 reset", 1000, 0);
    check_out("R1 reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    expect_v("R1 after release", 1000, 0);

    // conservative walk down to the padded floor
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 0, "R3 quiet minute");
    expect_v("R4 floor reached", 920, 0);
    cyc(1, 0, 0, 0, "R2 error rise");
    expect_v("R2 plus ten", 930, 0);
    cyc(1, 1, 0, 0, "R5 error with tick");
    expect_v("R5 rise wins", 940, 0);
    cyc(0, 1, 0, 0, "R5 next quiet tick");
    expect_v("R5 window restarted", 935, 0);
    for (int i = 0; i < 12; i++) cyc(1, 0, 0, 0, "R2 saturate");
    expect_v("R2 capped at max", 1000, 0);
    margin = 11'd995;
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, "R4 floor capped");
    expect_v("R4 floor capped at max", 1000, 0);
    margin = 11'd900;
    for (int i = 0; i < 16; i++) cyc(0, 1, 0, 0, "R3 walk");
    pad = 6'd18;
    cyc(0, 1, 0, 0, "R3 partial step");
    expect_v("R3 lands on floor", 918, 0);
    pad = 6'd20;
    cyc(0, 1, 0, 0, "R3 below floor");
    expect_v("R3 below floor unchanged", 918, 0);

    // entry into speculation
    cyc(0, 0, 0, 1, "R6 arm ignored for conservative class");
    expect_v("R6 no entry", 918, 0);
    aggr = 1'b1;
    cyc(0, 0, 0, 1, "R6 arm");
    expect_v("R6 entered", 918, 1);
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, "R7 step below margin");
    expect_v("R7 below margin", 868, 1);
    cyc(1, 0, 0, 0, "R7 error no rise");
    expect_v("R7 no rise on error", 868, 1);
    cyc(0, 1, 0, 0, "R8 rate at max");
    expect_v("R8 hold", 868, 2);
    cyc(0, 1, 0, 0, "R8 hold keeps");
    expect_v("R8 hold keeps code", 868, 2);
    cyc(1, 0, 0, 0, "R9 err");
    cyc(1, 0, 0, 0, "R9 err");
    cyc(0, 1, 0, 0, "R9 rate above max");
    expect_v("R9 exit lifts to floor", 920, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, "R12 stays conservative");
    expect_v("R12 no re-entry", 920, 0);
    cyc(0, 0, 0, 1, "R12 re-arm");
    expect_v("R12 re-entered", 920, 1);
    cyc(0, 0, 1, 0, "R9 context switch");
    expect_v("R9 ctx exit", 920, 0);
    cyc(0, 0, 0, 1, "R9 arm");
    tmin = 4'd1;
    cyc(0, 1, 0, 0, "R9 rate below min");
    expect_v("R9 min exit", 920, 0);
    tmin = 4'd0;

    // counter saturation
    tmax = 4'd15;
    cyc(0, 0, 0, 1, "R10 arm");
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, "R10 err burst");
    cyc(0, 1, 0, 0, "R10 saturated equals max");
    expect_v("R10 hold at saturation", 920, 2);
    tmax = 4'd14;
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, "R10 err burst");
    cyc(0, 1, 0, 0, "R10 saturated above max");
    expect_v("R10 exit above max", 920, 0);
    tmax = 4'd1;

    // lowered maximum
    aggr = 1'b0;
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, "R2 raise");
    expect_v("R2 raised to max", 1000, 0);
    vmax = 11'd950;
    cyc(0, 0, 0, 0, "R11 clamp");
    expect_v("R11 clamped", 950, 0);
    vmax = 11'd1000;
    cyc(0, 0, 0, 0, "R11 idle");

    // constrained random phase
    for (int n = 0; n < 6000; n++) begin
      bit e, t, c, s;
      if (n % 400 == 0) begin
        margin = VW'(800 + ($urandom % 150));
        pad    = PW'($urandom % 40);
        tmin   = CW'($urandom % 2);
        tmax   = CW'(1 + ($urandom % 3));
        aggr   = ($urandom % 4) != 0;
      end
      e = ($urandom % 9) == 0;
      t = ($urandom % 6) == 0;
      c = ($urandom % 80) == 0;
      s = ($urandom % 25) == 0;
      cyc(e, t, c, s, (m_mode == 0) ? "R2 R3 random conservative" : "R7 R8 R9 random speculation");
    end
    finish_run();
  end
endmodule